// File: doc/BRIEF.md
# Dual-Clock 32-to-8 Bit Width-Converting FIFO

This block carries a stream of 32-bit words from a producer clocked by `wr_clk` to a consumer clocked by `rd_clk`, where the two clocks have no fixed relation. Each word that is written leaves the read port as four 8-bit bytes, low byte first. Storage is sized for 2048 words by default. The write side sees a full flag and the read side sees an empty flag. A write refused because of full and a read refused because of empty each raise a one-cycle pulse in their own domain.

Pointers are kept in binary in their home domain and cross to the other domain in Gray code through two-flop synchronisers. The write pointer counts words. The read pointer counts bytes, and its word part is what is sent back to the writer, so a word's slot is released only after all four of its bytes have been read. Full leaves one word slot permanently unused. That keeps the compare simple, and because a stale read pointer can only make the writer see fewer free slots, the flag errs on the safe side.

A single active-low reset `rst_n` is sampled synchronously by each domain. It must be held low for several cycles of the slower clock.

Top module: `wide_narrow_fifo`

## Requirements
- R1: After reset, `rd_empty` is 1 and `wr_full`, `wr_overflow`, `rd_valid` and `rd_underflow` are 0.
- R2: Bytes leave in write order. Each word is split least significant byte first: bits [7:0], then [15:8], then [23:16], then [31:24].
- R3: With the reader idle and pointers settled, `wr_full` stays 0 while up to DEPTH-2 words are stored. It becomes 1 in the cycle after the edge that accepts word DEPTH-1 (2047 by default).
- R4: A write presented while `wr_full` is 1 is discarded and does not appear in the byte stream. `wr_overflow` is 1 for exactly the one cycle after that edge.
- R5: A read presented while `rd_empty` is 0 is accepted. In the following `rd_clk` cycle `rd_valid` is 1 and `rd_data` holds the byte.
- R6: A read presented while `rd_empty` is 1 returns no data. In the following cycle `rd_underflow` is 1, `rd_valid` is 0 and `rd_data` keeps its previous value.
- R7: `rd_empty` is evaluated per byte. It stays 0 while any byte of a partly read word remains, and becomes 1 in the cycle after the last stored byte is read.
- R8: A full FIFO stays full until all four bytes of the oldest word are read. Reading only three bytes does not clear `wr_full`. Reading the fourth byte clears it within a few `wr_clk` cycles.
- R9: The byte stream stays intact when the write clock is faster than the read clock and when it is slower, including periods of back-pressure from full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wr_en | input | 1 | Write request |
| wr_data | input | 32 | Word to write |
| wr_full | output | 1 | No free word slot (one slot always held back) |
| wr_overflow | output | 1 | One-cycle pulse: previous write was discarded |
| rd_en | input | 1 | Read request for one byte |
| rd_data | output | 8 | Byte returned one cycle after an accepted read |
| rd_valid | output | 1 | `rd_data` carries a newly read byte |
| rd_empty | output | 1 | No complete byte stored |
| rd_underflow | output | 1 | One-cycle pulse: previous read found the FIFO empty |

## Verification
A single known word read back byte by byte separates the correct low-byte-first split from a reversed or shifted lane order. Filling from idle to exactly DEPTH-1 words and then attempting one more write separates an off-by-one full threshold from the correct one, and shows that discarded data never reaches the stream. From the full state, reading three bytes and then the fourth distinguishes release at word granularity from release per byte. Long streams with the write clock first faster and then slower than the read clock, compared against a byte queue, expose pointer-crossing and ordering faults under both back-pressure and starvation.

// File: rtl/wnf_pkg.sv
// Package: shared pointer type and Gray-code helpers for the width-converting FIFO.
// Assumes pointer widths never exceed PTR_MAX bits; callers cast to and from ptr_t.
package wnf_pkg;

    localparam int unsigned PTR_MAX = 32;

    typedef logic [PTR_MAX-1:0] ptr_t;

    // Binary to reflected Gray code.
    function automatic ptr_t to_gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code to binary; zero-extended upper bits are harmless.
    function automatic ptr_t from_gray(ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/wnf_ptr_sync.sv
// Module: two-flop synchroniser for a Gray-coded pointer, converted to binary
// in the destination domain after the second flop.
// Assumes the source changes the Gray input by at most one bit per source edge.
module wnf_ptr_sync #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    import wnf_pkg::*;

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Two-stage capture of the foreign-domain Gray pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= gray_in;
            stable_q <= meta_q;
        end
    end

    // Decode the settled Gray value to binary for arithmetic.
    always_comb begin
        bin_out = W'(from_gray(ptr_t'(stable_q)));
    end

endmodule

// File: rtl/wnf_store.sv
// Module: word storage, written from the write domain and read asynchronously
// by address from the read domain.
// Assumes the reader only addresses words whose pointer has already crossed.
module wnf_store #(
    parameter int unsigned DEPTH  = 2048,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] cells [DEPTH];

    // Store an accepted word; contents need no reset.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Present the word at the reader's current word address.
    assign rdata = cells[raddr];

endmodule

// File: rtl/wnf_wr_ctrl.sv
// Module: write-side pointer, full detection and overflow pulse.
// Assumes rd_word_bin is the read word pointer already synchronised into wr_clk.
// Full holds one slot back: it asserts at DEPTH-1 stored words.
module wnf_wr_ctrl #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] rd_word_bin,
    output logic          full,
    output logic          overflow,
    output logic          accept,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray
);
    import wnf_pkg::*;

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic [PW-1:0] level;

    assign level    = wbin - rd_word_bin;
    assign full     = (level >= PW'(DEPTH - 1));
    assign accept   = wr_en && !full;
    assign wbin_nxt = wbin + PW'(1);
    assign waddr    = wbin[AW-1:0];

    // Advance the word pointer on accepted writes and flag discarded ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin     <= '0;
            wgray    <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= wr_en && full;
            if (accept) begin
                wbin  <= wbin_nxt;
                wgray <= PW'(to_gray(ptr_t'(wbin_nxt)));
            end
        end
    end

endmodule

// File: rtl/wnf_rd_ctrl.sv
// Module: read-side byte pointer, lane selection, empty detection and the
// registered byte output with valid and underflow pulses.
// Assumes wr_word_bin is the write word pointer synchronised into rd_clk.
// Only the word part of the byte pointer is sent back, so a slot is freed
// once all of its lanes have been read.
module wnf_rd_ctrl #(
    parameter int unsigned DEPTH  = 2048,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned BYTE_W = 8,
    localparam int unsigned RATIO = WORD_W / BYTE_W,
    localparam int unsigned LW    = $clog2(RATIO),
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned PW    = AW + 1,
    localparam int unsigned RPW   = PW + LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [PW-1:0]     wr_word_bin,
    input  logic [WORD_W-1:0] mem_word,
    output logic [AW-1:0]     raddr,
    output logic [PW-1:0]     rgray,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_empty,
    output logic              rd_underflow
);
    import wnf_pkg::*;

    logic [RPW-1:0]    rbin;
    logic [RPW-1:0]    rbin_nxt;
    logic [BYTE_W-1:0] lanes [RATIO];
    logic [BYTE_W-1:0] cur_byte;
    logic              take;

    // Split the current word into lanes, lane 0 holding the low bits.
    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        assign lanes[g] = mem_word[g*BYTE_W +: BYTE_W];
    end

    assign cur_byte = lanes[rbin[LW-1:0]];
    assign raddr    = rbin[LW+AW-1:LW];
    assign rd_empty = (rbin == {wr_word_bin, LW'(0)});
    assign take     = rd_en && !rd_empty;
    assign rbin_nxt = rbin + RPW'(1);

    // Advance the byte pointer, register the byte and raise the pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin         <= '0;
            rgray        <= '0;
            rd_data      <= '0;
            rd_valid     <= 1'b0;
            rd_underflow <= 1'b0;
        end else begin
            rd_valid     <= take;
            rd_underflow <= rd_en && rd_empty;
            if (take) begin
                rd_data <= cur_byte;
                rbin    <= rbin_nxt;
                rgray   <= PW'(to_gray(ptr_t'(rbin_nxt[RPW-1:LW])));
            end
        end
    end

endmodule

// File: rtl/wide_narrow_fifo.sv
// Module: dual-clock FIFO taking WR_W-bit words and returning RD_W-bit pieces,
// lowest piece first. Word pointers cross domains in Gray code.
// Assumes DEPTH and WR_W/RD_W are powers of two with WR_W/RD_W >= 2, and a
// reset held low for several cycles of both clocks.
module wide_narrow_fifo #(
    parameter int unsigned DEPTH = 2048,
    parameter int unsigned WR_W  = 32,
    parameter int unsigned RD_W  = 8
) (
    input  logic            wr_clk,
    input  logic            rd_clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WR_W-1:0] wr_data,
    output logic            wr_full,
    output logic            wr_overflow,
    input  logic            rd_en,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_valid,
    output logic            rd_empty,
    output logic            rd_underflow
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic          wr_take;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] rd_word_in_wr;
    logic [PW-1:0] wr_word_in_rd;
    logic [WR_W-1:0] mem_word;

    wnf_wr_ctrl #(.DEPTH(DEPTH)) u_wr_ctrl (
        .clk        (wr_clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_word_bin(rd_word_in_wr),
        .full       (wr_full),
        .overflow   (wr_overflow),
        .accept     (wr_take),
        .waddr      (waddr),
        .wgray      (wgray)
    );

    wnf_ptr_sync #(.W(PW)) u_sync_to_rd (
        .clk    (rd_clk),
        .rst_n  (rst_n),
        .gray_in(wgray),
        .bin_out(wr_word_in_rd)
    );

    wnf_ptr_sync #(.W(PW)) u_sync_to_wr (
        .clk    (wr_clk),
        .rst_n  (rst_n),
        .gray_in(rgray),
        .bin_out(rd_word_in_wr)
    );

    wnf_store #(.DEPTH(DEPTH), .WORD_W(WR_W)) u_store (
        .wr_clk(wr_clk),
        .we    (wr_take),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_word)
    );

    wnf_rd_ctrl #(.DEPTH(DEPTH), .WORD_W(WR_W), .BYTE_W(RD_W)) u_rd_ctrl (
        .clk         (rd_clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_word_bin (wr_word_in_rd),
        .mem_word    (mem_word),
        .raddr       (raddr),
        .rgray       (rgray),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .rd_empty    (rd_empty),
        .rd_underflow(rd_underflow)
    );

endmodule

// File: rtl/wide_narrow_fifo_chk.sv
// Module: port-level protocol checker for wide_narrow_fifo, bound to every instance.
// Assumes nothing beyond the port behaviour stated in the requirements.
module wide_narrow_fifo_chk #(
    parameter int unsigned RD_W = 8
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic            wr_full,
    input logic            wr_overflow,
    input logic            rd_en,
    input logic [RD_W-1:0] rd_data,
    input logic            rd_valid,
    input logic            rd_empty,
    input logic            rd_underflow
);
    // R4: an overflow pulse follows only a write attempted while full.
    p_overflow_cause_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        wr_overflow |-> ($past(wr_en) && $past(wr_full)));

    // R4: a write attempted while full raises the pulse on the next cycle.
    p_overflow_seen_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && wr_full) |=> wr_overflow);

    // R5: valid data follows only an accepted read.
    p_valid_cause_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_valid |-> ($past(rd_en) && !$past(rd_empty)));

    // R6: an underflow pulse follows only a read attempted while empty.
    p_underflow_cause_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_underflow |-> ($past(rd_en) && $past(rd_empty)));

    // R6: the byte output does not move on an underflow.
    p_underflow_hold_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        rd_underflow |-> ($stable(rd_data) && !rd_valid));

    // R5: without a read request no new byte is presented.
    p_idle_quiet_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

endmodule

bind wide_narrow_fifo wide_narrow_fifo_chk #(.RD_W(RD_W)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_full     (wr_full),
    .wr_overflow (wr_overflow),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .rd_empty    (rd_empty),
    .rd_underflow(rd_underflow)
);

// File: tb/wide_narrow_fifo_bench.sv
`timescale 1ns/1ps
module wide_narrow_fifo_bench;

    localparam int unsigned DEPTH = 2048;

    logic        wr_clk = 1'b0;
    logic        rd_clk = 1'b0;
    logic        rst_n  = 1'b0;
    logic        wr_en  = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_full;
    logic        wr_overflow;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        rd_empty;
    logic        rd_underflow;

    realtime     rd_half = 5.0;
    int          checks  = 0;
    int          errors  = 0;
    int unsigned wcnt    = 0;
    bit          done    = 1'b0;
    logic [7:0]  model [$];

    wide_narrow_fifo #(.DEPTH(DEPTH)) u_wide_narrow_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full), .wr_overflow(wr_overflow),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .rd_empty(rd_empty), .rd_underflow(rd_underflow)
    );

    always #5.0 wr_clk = ~wr_clk;
    always #(rd_half) rd_clk = ~rd_clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic logic [31:0] gen_word(input int unsigned c);
        return (c * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    task automatic push_model(input logic [31:0] w);
        for (int k = 0; k < 4; k++) model.push_back(w[8*k +: 8]);
    endtask

    task automatic wait_wr(input int n);
        for (int i = 0; i < n; i++) @(negedge wr_clk);
    endtask

    // One isolated read; returns the byte and checks the valid pulse (R5).
    task automatic read_one(output logic [7:0] b);
        @(negedge rd_clk);
        while (rd_empty) @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(rd_valid === 1'b1, "R5", "valid after accepted read", 32'(rd_valid), 32'd1);
        b = rd_data;
    endtask

    // Write n generated words back to back, pausing while full.
    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            while (wr_full) begin
                wr_en = 1'b0;
                @(negedge wr_clk);
            end
            wr_en   = 1'b1;
            wr_data = gen_word(wcnt);
            push_model(wr_data);
            wcnt++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
    endtask

    // Read n bytes back to back when available and compare with the model (R2, R9).
    task automatic rd_burst(input int n);
        bit pend = 1'b0;
        logic [7:0] exp;
        int got = 0;
        while (got < n || pend) begin
            @(negedge rd_clk);
            if (pend) begin
                exp = model.pop_front();
                check(rd_valid === 1'b1 && rd_data === exp, "R9", "streamed byte",
                      32'(rd_data), 32'(exp));
            end
            if (got < n && !rd_empty) begin
                rd_en = 1'b1;
                pend  = 1'b1;
                got++;
            end else begin
                rd_en = 1'b0;
                pend  = 1'b0;
            end
        end
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check(rd_empty === 1'b1, "R1", "empty after reset", 32'(rd_empty), 32'd1);
        check(wr_full === 1'b0, "R1", "full after reset", 32'(wr_full), 32'd0);
        check(wr_overflow === 1'b0 && rd_underflow === 1'b0, "R1", "pulses after reset",
              {30'd0, wr_overflow, rd_underflow}, 32'd0);
        check(rd_valid === 1'b0, "R1", "valid after reset", 32'(rd_valid), 32'd0);
    endtask

    task automatic t_byte_order();
        logic [7:0] b;
        logic [7:0] want [4] = '{8'hD4, 8'hC3, 8'hB2, 8'hA1};
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = 32'hA1B2C3D4;
        @(negedge wr_clk);
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            read_one(b);
            check(b === want[k], "R2", "lane order", 32'(b), 32'(want[k]));
        end
    endtask

    task automatic t_underflow();
        logic [7:0] last;
        wait_wr(8);
        @(negedge rd_clk);
        check(rd_empty === 1'b1, "R7", "empty after last byte", 32'(rd_empty), 32'd1);
        last  = rd_data;
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        check(rd_underflow === 1'b1, "R6", "underflow pulse", 32'(rd_underflow), 32'd1);
        check(rd_valid === 1'b0, "R6", "no valid on underflow", 32'(rd_valid), 32'd0);
        check(rd_data === last, "R6", "data held", 32'(rd_data), 32'(last));
        @(negedge rd_clk);
        check(rd_underflow === 1'b0, "R6", "underflow one cycle", 32'(rd_underflow), 32'd0);
    endtask

    task automatic t_capacity();
        logic [7:0] b;
        logic [7:0] exp;
        rd_half = 2.0;
        wait_wr(10);
        for (int i = 0; i < DEPTH - 2; i++) begin
            @(negedge wr_clk);
            wr_en   = 1'b1;
            wr_data = gen_word(wcnt);
            push_model(wr_data);
            wcnt++;
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_full === 1'b0, "R3", "not full at DEPTH-2", 32'(wr_full), 32'd0);
        wr_en   = 1'b1;
        wr_data = gen_word(wcnt);
        push_model(wr_data);
        wcnt++;
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_full === 1'b1, "R3", "full at DEPTH-1", 32'(wr_full), 32'd1);
        // Attempt one write into the full FIFO; it must be discarded (R4).
        wr_en   = 1'b1;
        wr_data = 32'hDEADBEEF;
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_overflow === 1'b1, "R4", "overflow pulse", 32'(wr_overflow), 32'd1);
        @(negedge wr_clk);
        check(wr_overflow === 1'b0, "R4", "overflow one cycle", 32'(wr_overflow), 32'd0);
        // Three bytes of the oldest word do not free its slot (R8).
        for (int k = 0; k < 3; k++) begin
            read_one(b);
            exp = model.pop_front();
            check(b === exp, "R2", "byte from full fifo", 32'(b), 32'(exp));
        end
        wait_wr(10);
        check(wr_full === 1'b1, "R8", "full after three bytes", 32'(wr_full), 32'd1);
        read_one(b);
        exp = model.pop_front();
        check(b === exp, "R2", "fourth byte", 32'(b), 32'(exp));
        wait_wr(10);
        check(wr_full === 1'b0, "R8", "full clears after whole word", 32'(wr_full), 32'd0);
        // Drain to one byte, then check empty at byte granularity (R7).
        rd_burst(model.size() - 1);
        @(negedge rd_clk);
        check(rd_empty === 1'b0, "R7", "one byte left", 32'(rd_empty), 32'd0);
        read_one(b);
        exp = model.pop_front();
        check(b === exp, "R4", "discarded word absent", 32'(b), 32'(exp));
        check(rd_empty === 1'b1, "R7", "empty after last byte", 32'(rd_empty), 32'd1);
    endtask

    task automatic t_stream(input realtime half, input int words);
        rd_half = half;
        wait_wr(10);
        fork
            wr_burst(words);
            rd_burst(4 * words);
        join
        check(model.size() == 0, "R9", "model drained", 32'(model.size()), 32'd0);
        @(negedge rd_clk);
        check(rd_empty === 1'b1, "R7", "empty after stream", 32'(rd_empty), 32'd1);
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_wr(8);
        rst_n = 1'b1;
        wait_wr(2);
        t_reset();
        t_byte_order();
        t_underflow();
        t_capacity();
        t_stream(13.0, 3000);
        t_stream(2.0, 1500);
        finish_run();
    end

endmodule